// File: doc/BRIEF.md
# Clock-Recovery Lock Arbiter

This block chooses the reference source for a receive clock-recovery loop: either the incoming serial data (track data) or the local reference clock (hold frequency). Once per gate window of `2^GATE_LOG2` reference ticks it counts recovered words and takes the absolute difference from the ideal count. It converts that difference into a frequency error in parts per million. The error is classified against two pairs of thresholds. The pair in use depends on whether the loop is currently frequency-locked, which gives the classification hysteresis.

In parallel, a run-length monitor watches each recovered word. A word whose bits are all equal is a uniform word. A long stretch of uniform words of one polarity means the signal is gone. The loop is steered to data only while the frequency state is locked and no run-length violation is present. Any violation returns it to the reference immediately. The select moves only on a cycle that carries a recovered word, so the recovered byte clock stays phase-continuous.

Inputs arrive as single-cycle pulses in the `clk_i` domain. `ref_tick_i` marks one reference cycle. `word_vld_i` marks one recovered word, and `word_i` carries that word.

Top module: `cr_lock_arbiter`

## Requirements
- R1: While `rst_ni` is low, `sel_data_o`, `lock_o`, `freq_viol_o` and `run_viol_o` are 0, taking effect without waiting for a clock edge.
- R2: A gate window ends on the `2^GATE_LOG2`-th reference tick after reset or after the previous window. Words pulsed on that final cycle belong to the ending window. The error is `|words - 2^GATE_LOG2| * 1e6 / 2^GATE_LOG2` ppm. `lock_o`, `freq_viol_o` and `run_viol_o` change only at the clock edge that ends a window.
- R3: When locked, an error strictly below 488 ppm keeps `lock_o`=1. An error strictly above 732 ppm clears `lock_o` and sets `freq_viol_o`.
- R4: When locked, an error from 488 to 732 ppm inclusive keeps `lock_o`=1 with `freq_viol_o`=0.
- R5: When unlocked, an error strictly below 244 ppm sets `lock_o`. An error strictly above 366 ppm keeps `lock_o`=0 and sets `freq_viol_o`.
- R6: When unlocked, an error from 244 to 366 ppm inclusive keeps `lock_o`=0 with `freq_viol_o`=0.
- R7: A word is uniform when all `WORD_W` bits are 1 or all are 0. A run-length violation is present from the `RUN_WORDS`-th (12th) consecutive uniform word of one polarity onward. Eleven such words raise no violation. A non-uniform word, or a uniform word of the other polarity, restarts the run.
- R8: After a clock edge carrying a word, `sel_data_o` equals the post-edge lock state AND NOT (a run-length violation is present after that word). It therefore drops at the edge of the 12th uniform word. It recovers at the edge of the next non-uniform word if still locked.
- R9: `sel_data_o` changes only at a clock edge where `word_vld_i` is 1. A lock gained at a window end that carries no word reaches `sel_data_o` at the next word.
- R10: `run_viol_o` shows whether a run-length violation was present on any word of the window just ended. A run-length violation does not change `lock_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One pulse per reference clock cycle |
| word_vld_i | input | 1 | One pulse per recovered word (word boundary) |
| word_i | input | WORD_W | Recovered parallel word |
| sel_data_o | output | 1 | 1: loop tracks data; 0: loop tracks reference |
| lock_o | output | 1 | Frequency lock state |
| freq_viol_o | output | 1 | Last window's error exceeded the exit limit for its state |
| run_viol_o | output | 1 | Run-length violation seen in the last window |

## Verification
A wrong hysteresis state shows at `lock_o` only at the next window end, one gate window after the fault, and shows at `sel_data_o` at the word after that. The threshold pairs are therefore probed across consecutive windows that start from both lock states. The error steps sit exactly inside each band. A miscounted run is visible at `sel_data_o` one word after the 11th or 12th uniform word, so the select is compared on every cycle. A window closed one tick early or late shifts every status edge and breaks the per-cycle comparison within the first window.

// File: rtl/cr_lock_pkg.sv
package cr_lock_pkg;
  typedef enum logic [1:0] {
    FC_PASS = 2'd0,
    FC_HOLD = 2'd1,
    FC_FAIL = 2'd2
  } freq_class_e;

  localparam logic [63:0] PPM_SCALE = 64'd1_000_000;
endpackage

// File: rtl/cr_freq_meter.sv
module cr_freq_meter #(
  parameter int GATE_LOG2 = 14,
  parameter int CNT_W     = GATE_LOG2 + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             word_vld_i,
  output logic             win_done_o,
  output logic [CNT_W-1:0] diff_o
);
  localparam logic [CNT_W-1:0] GATE_CNT = CNT_W'(1) << GATE_LOG2;

  logic [GATE_LOG2-1:0] tick_q;
  logic [CNT_W-1:0]     word_q;
  logic [CNT_W-1:0]     total;

  assign win_done_o = ref_tick_i && (&tick_q);
  // saturate instead of wrapping on a runaway word rate
  assign total  = (&word_q) ? word_q : word_q + CNT_W'(word_vld_i);
  assign diff_o = (total >= GATE_CNT) ? total - GATE_CNT : GATE_CNT - total;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      word_q <= '0;
    end else begin
      if (ref_tick_i) tick_q <= tick_q + 1'b1;
      word_q <= win_done_o ? '0 : total;
    end
  end
endmodule

// File: rtl/cr_run_check.sv
module cr_run_check #(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              win_done_i,
  output logic              run_bad_o,
  output logic              run_viol_o
);
  localparam int RUN_W = $clog2(RUN_WORDS + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_WORDS);

  logic [RUN_W-1:0] run_q, run_nxt;
  logic             pol_q, sticky_q, viol_q;
  logic             all1, all0, bad_now;

  assign all1 = &word_i;
  assign all0 = ~|word_i;

  always_comb begin
    if (!(all1 || all0))                     run_nxt = '0;
    else if (run_q == '0 || pol_q != all1)   run_nxt = RUN_W'(1);
    else if (run_q >= RUN_LIM)               run_nxt = RUN_LIM;
    else                                     run_nxt = run_q + 1'b1;
  end

  assign run_bad_o  = word_vld_i ? (run_nxt >= RUN_LIM) : (run_q >= RUN_LIM);
  assign bad_now    = word_vld_i && (run_nxt >= RUN_LIM);
  assign run_viol_o = viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      pol_q    <= 1'b0;
      sticky_q <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      if (word_vld_i) begin
        run_q <= run_nxt;
        pol_q <= all1;
      end
      if (win_done_i) begin
        viol_q   <= sticky_q | bad_now;
        sticky_q <= 1'b0;
      end else begin
        sticky_q <= sticky_q | bad_now;
      end
    end
  end
endmodule

// File: rtl/cr_lock_fsm.sv
module cr_lock_fsm
  import cr_lock_pkg::*;
#(
  parameter int GATE_LOG2  = 14,
  parameter int CNT_W      = GATE_LOG2 + 2,
  parameter int ENTER_PPM  = 244,
  parameter int STAYOUT_PPM = 366,
  parameter int KEEP_PPM   = 488,
  parameter int DROP_PPM   = 732
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_done_i,
  input  logic [CNT_W-1:0] diff_i,
  input  logic             word_vld_i,
  input  logic             run_bad_i,
  output logic             sel_data_o,
  output logic             lock_o,
  output logic             freq_viol_o
);
  localparam logic [63:0] LIM_ENTER = 64'(ENTER_PPM)   << GATE_LOG2;
  localparam logic [63:0] LIM_OUT   = 64'(STAYOUT_PPM) << GATE_LOG2;
  localparam logic [63:0] LIM_KEEP  = 64'(KEEP_PPM)    << GATE_LOG2;
  localparam logic [63:0] LIM_DROP  = 64'(DROP_PPM)    << GATE_LOG2;

  logic        lock_q, lock_nxt, sel_q, fviol_q;
  logic [63:0] err;
  logic        pass, fail;
  freq_class_e cls;

  assign err = 64'(diff_i) * PPM_SCALE;

  always_comb begin
    // thresholds depend on current state: hysteresis
    if (lock_q) begin
      pass = err < LIM_KEEP;
      fail = err > LIM_DROP;
    end else begin
      pass = err < LIM_ENTER;
      fail = err > LIM_OUT;
    end
    cls = fail ? FC_FAIL : (pass ? FC_PASS : FC_HOLD);
    lock_nxt = lock_q;
    if (win_done_i) begin
      case (cls)
        FC_PASS: lock_nxt = 1'b1;
        FC_FAIL: lock_nxt = 1'b0;
        default: lock_nxt = lock_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      fviol_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      lock_q <= lock_nxt;
      if (win_done_i) fviol_q <= (cls == FC_FAIL);
      if (word_vld_i) sel_q <= lock_nxt & ~run_bad_i;
    end
  end

  assign sel_data_o  = sel_q;
  assign lock_o      = lock_q;
  assign freq_viol_o = fviol_q;
endmodule

// File: rtl/cr_lock_arbiter.sv
module cr_lock_arbiter #(
  parameter int GATE_LOG2   = 14,
  parameter int WORD_W      = 10,
  parameter int RUN_WORDS   = 12,
  parameter int ENTER_PPM   = 244,
  parameter int STAYOUT_PPM = 366,
  parameter int KEEP_PPM    = 488,
  parameter int DROP_PPM    = 732
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sel_data_o,
  output logic              lock_o,
  output logic              freq_viol_o,
  output logic              run_viol_o
);
  localparam int CNT_W = GATE_LOG2 + 2;

  logic             win_done;
  logic [CNT_W-1:0] diff;
  logic             run_bad;

  cr_freq_meter #(
    .GATE_LOG2(GATE_LOG2),
    .CNT_W    (CNT_W)
  ) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_tick_i(ref_tick_i),
    .word_vld_i(word_vld_i),
    .win_done_o(win_done),
    .diff_o    (diff)
  );

  cr_run_check #(
    .WORD_W   (WORD_W),
    .RUN_WORDS(RUN_WORDS)
  ) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_vld_i(word_vld_i),
    .word_i    (word_i),
    .win_done_i(win_done),
    .run_bad_o (run_bad),
    .run_viol_o(run_viol_o)
  );

  cr_lock_fsm #(
    .GATE_LOG2  (GATE_LOG2),
    .CNT_W      (CNT_W),
    .ENTER_PPM  (ENTER_PPM),
    .STAYOUT_PPM(STAYOUT_PPM),
    .KEEP_PPM   (KEEP_PPM),
    .DROP_PPM   (DROP_PPM)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_done_i (win_done),
    .diff_i     (diff),
    .word_vld_i (word_vld_i),
    .run_bad_i  (run_bad),
    .sel_data_o (sel_data_o),
    .lock_o     (lock_o),
    .freq_viol_o(freq_viol_o)
  );
endmodule

// File: rtl/cr_lock_arbiter_chk.sv
module cr_lock_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic word_vld_i,
  input logic sel_data_o,
  input logic lock_o,
  input logic freq_viol_o,
  input logic run_viol_o,
  input logic win_done,
  input logic run_bad
);
  a_r1_reset_to_ref: assert property (@(posedge clk_i)
    !rst_ni |-> (!sel_data_o && !lock_o && !freq_viol_o && !run_viol_o));

  a_r8_sel_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_data_o |-> lock_o);

  a_r8_run_forces_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && run_bad) |=> !sel_data_o);

  a_r9_sel_at_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_data_o) |-> $past(word_vld_i));

  a_r2_status_at_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lock_o) || !$stable(freq_viol_o) || !$stable(run_viol_o)) |-> $past(win_done));

  a_r3_viol_means_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_viol_o |-> !lock_o);
endmodule

bind cr_lock_arbiter cr_lock_arbiter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_vld_i (word_vld_i),
  .sel_data_o (sel_data_o),
  .lock_o     (lock_o),
  .freq_viol_o(freq_viol_o),
  .run_viol_o (run_viol_o),
  .win_done   (win_done),
  .run_bad    (run_bad)
);

// File: tb/cr_lock_arbiter_bench.sv
`timescale 1ns/1ps
module cr_lock_arbiter_bench;
  localparam int G      = 12;
  localparam int GATE   = 1 << G;
  localparam int WIN    = 2 * GATE;
  localparam int WW     = 10;
  localparam int RUNLIM = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ref_tick = 1'b0;
  logic          word_vld = 1'b0;
  logic [WW-1:0] word = '0;
  logic          sel_data, lock, fviol, rviol;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // requirement-level model
  bit exp_lock, exp_fv, exp_rv, exp_sel, sticky, last_pol;
  int run;
  bit obs_first, obs_mid, obs11, obs12, obs13;

  always #5 clk = ~clk;

  cr_lock_arbiter #(.GATE_LOG2(G), .WORD_W(WW), .RUN_WORDS(RUNLIM)) u_cr_lock_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick), .word_vld_i(word_vld),
    .word_i(word), .sel_data_o(sel_data), .lock_o(lock), .freq_viol_o(fviol),
    .run_viol_o(rviol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // classify per R3..R6 thresholds in ppm
  function automatic void classify(input int diff);
    longint err = longint'(diff) * 1000000;
    longint g = longint'(GATE);
    bit pass, fail;
    if (exp_lock) begin
      pass = err < 488 * g;
      fail = err > 732 * g;
    end else begin
      pass = err < 244 * g;
      fail = err > 366 * g;
    end
    if (pass) exp_lock = 1'b1;
    if (fail) exp_lock = 1'b0;
    exp_fv = fail;
  endfunction

  task automatic run_window(input int extra, input int missing, input int n1,
                            input int n0, input bit late_end, input string tag);
    int mism = 0;
    int diff = (extra > missing) ? extra - missing : missing - extra;
    for (int c = 0; c < WIN; c++) begin
      bit tk, wv, uni, bad;
      logic [WW-1:0] wd;
      int w;
      @(negedge clk);
      if (c > 0 && sel_data !== exp_sel) mism++;
      if (c == 1) obs_first = sel_data;
      if (c == 4000) obs_mid = lock;
      if (c == 2 * (99 + 11) + 1) obs11 = sel_data;
      if (c == 2 * (99 + 12) + 1) obs12 = sel_data;
      if (c == 2 * (99 + 13) + 1) obs13 = sel_data;
      tk = (c % 2 == 0);
      w  = c / 2;
      wd = (w % 2 == 0) ? WW'(10'h155) : WW'(10'h333);
      if (tk) begin
        wv = !(missing > 0 && c >= 1000 && c < 1000 + 2 * missing);
        if (late_end && c == WIN - 2) wv = 1'b0;
        if (w >= 100 && w < 100 + n1) wd = '1;
        else if (w >= 100 + n1 && w < 100 + n1 + n0) wd = '0;
      end else begin
        wv = (extra > 0 && c >= 1001 && c < 1001 + 2 * extra);
        if (late_end && c == WIN - 3) wv = 1'b1;
        wd = WW'(10'h2AA);
      end
      ref_tick = tk;
      word_vld = wv;
      word     = wd;
      bad = 1'b0;
      if (wv) begin
        uni = (&wd) || (~|wd);
        if (!uni) run = 0;
        else if (run == 0 || last_pol != (&wd)) run = 1;
        else if (run < RUNLIM) run++;
        last_pol = &wd;
        bad = run >= RUNLIM;
        sticky |= bad;
      end
      if (c == WIN - 2) begin
        classify(diff + ((late_end && extra == 0 && missing == 0) ? 0 : 0));
        exp_rv = sticky;
        sticky = 1'b0;
      end
      if (wv) exp_sel = exp_lock && !bad;
    end
    @(negedge clk);
    if (sel_data !== exp_sel) mism++;
    ref_tick = 1'b0;
    word_vld = 1'b0;
    chk(mism == 0, {"R8 sel tracking ", tag}, mism, 0);
    chk(lock == exp_lock, {"R3-R6 lock ", tag}, int'(lock), int'(exp_lock));
    chk(fviol == exp_fv, {"freq_viol ", tag}, int'(fviol), int'(exp_fv));
    chk(rviol == exp_rv, {"R10 run_viol ", tag}, int'(rviol), int'(exp_rv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sel_data == 1'b0, "R1 sel in reset", int'(sel_data), 0);
    chk(lock == 1'b0, "R1 lock in reset", int'(lock), 0);
    chk(fviol == 1'b0 && rviol == 1'b0, "R1 status in reset", int'(fviol) + int'(rviol), 0);
    rst_ni = 1'b1;

    run_window(0, 0, 0, 0, 1'b0, "W1 enter");       // R5 lock from 0 ppm
    chk(lock == 1'b1, "R5 enter below 244ppm", int'(lock), 1);
    run_window(1, 0, 0, 0, 1'b0, "W2 keep");        // R3 244ppm while locked
    chk(lock == 1'b1, "R3 keep below 488ppm", int'(lock), 1);
    run_window(0, 2, 0, 0, 1'b0, "W3 band");        // R4 488ppm hold
    chk(lock == 1'b1 && fviol == 1'b0, "R4 hold in band", int'(lock), 1);
    run_window(3, 0, 0, 0, 1'b0, "W4 drop");        // R3 732+ppm
    chk(obs_mid == 1'b1, "R2 lock unchanged mid-window", int'(obs_mid), 1);
    chk(lock == 1'b0 && fviol == 1'b1, "R3 drop above 732ppm", int'(fviol), 1);
    chk(sel_data == 1'b0, "R8 sel after drop", int'(sel_data), 0);
    run_window(1, 0, 0, 0, 1'b0, "W5 band");        // R6 244ppm unlocked
    chk(lock == 1'b0 && fviol == 1'b0, "R6 hold in band", int'(fviol), 0);
    run_window(0, 2, 0, 0, 1'b0, "W6 stayout");     // R5 488 > 366
    chk(lock == 1'b0 && fviol == 1'b1, "R5 stay out above 366ppm", int'(fviol), 1);
    run_window(0, 0, 0, 0, 1'b1, "W7 late");        // R9 no word at window end
    chk(lock == 1'b1 && sel_data == 1'b0, "R9 sel waits for word", int'(sel_data), 0);
    run_window(0, 0, 11, 0, 1'b0, "W8 run11");
    chk(obs_first == 1'b1, "R9 sel follows first word", int'(obs_first), 1);
    chk(obs11 == 1'b1, "R7 eleven uniform words no violation", int'(obs11), 1);
    chk(rviol == 1'b0, "R7 no run_viol for 11", int'(rviol), 0);
    run_window(0, 0, 0, 12, 1'b0, "W9 run12");
    chk(obs12 == 1'b0, "R8 drop at 12th uniform word", int'(obs12), 0);
    chk(obs13 == 1'b1, "R8 recover on non-uniform word", int'(obs13), 1);
    chk(rviol == 1'b1 && lock == 1'b1, "R10 run_viol set, lock kept", int'(rviol), 1);
    run_window(0, 0, 6, 6, 1'b0, "W10 split");
    chk(rviol == 1'b0, "R7 polarity change restarts run", int'(rviol), 0);

    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(sel_data == 1'b0 && lock == 1'b0, "R1 async reset", int'(lock), 0);
    chk(fviol == 1'b0 && rviol == 1'b0, "R1 async reset status", int'(rviol), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule